// File: doc/BRIEF.md
# Row-Streamed 4x4 SAD Engine

This block measures how well one 16x16 candidate block matches the current block during integer motion search. It receives both blocks one pixel row at a time. Each accepted row carries sixteen candidate pixels and sixteen current pixels, 8 bits each, qualified by a valid bit. Sixteen absolute-difference elements work side by side on a row. Every group of four adjacent elements feeds an adder tree and a running accumulator. The accumulator belongs to one column of 4x4 sub-blocks.

Every fourth accepted row closes a horizontal band of sub-blocks. Each group's accumulated sum is then steered by the row counter into the holding register for that band, and the accumulator starts again from zero. After sixteen accepted rows all sixteen 4x4 SADs sit in registers and a one-cycle done strobe marks them. A downstream tree can merge them into larger partitions. The next candidate block may start on the cycle that follows its last row.

Top module: `sad4x4_row_unit`

## Requirements
- R1: While rst_n is low at a clock edge, all of sad_out is cleared to zero and done is cleared to low, whatever in_valid carries.
- R2: Each element computes the unsigned magnitude |cand - cur| of one pixel pair. Pixel column i (0..15) occupies bits [8i+7:8i] of both cand_row and cur_row.
- R3: A 4x4 SAD is the sum of the sixteen pixel magnitudes in the block column c (pixel columns 4c..4c+3) over the four rows of one band.
- R4: The SAD for block row br and block column bc has index k = 4*br + bc and sits at bits [12k+11:12k] of sad_out. br is the position of the accepted row within the block, divided by 4, counting accepted rows from 0.
- R5: Each 4x4 SAD is 12 bits wide and holds the full range without wrap. Cand 255 against cur 0 (or the reverse) on every pixel gives 4080 in every slot.
- R6: done is high for exactly one cycle, on the cycle after the 16th accepted row of a block, and at no other time.
- R7: Cycles with in_valid low are ignored. They neither advance the row count nor change the accumulation, and sad_out holds its value across them.
- R8: A new block may begin on the cycle right after the previous block's 16th row. Its sums then start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the row on cand_row and cur_row |
| cand_row | input | 128 | Sixteen candidate pixels, column i at bits [8i+7:8i] |
| cur_row | input | 128 | Sixteen current-block pixels, same layout |
| sad_out | output | 192 | Sixteen 12-bit 4x4 SADs in raster order of sub-blocks |
| done | output | 1 | One-cycle strobe: all sixteen SADs of a block are ready |

## Verification
The assertions check several properties on every cycle: that done follows only the 16th accepted row and never lasts two cycles, that sad_out stays still through idle cycles, that every slot stays within 4080, and that reset clears the state. The numerical content of the SADs, their placement by sub-block index, and correct restart on back-to-back blocks cannot be shown by these properties. The bench's scoreboard shows them instead, by comparing each completed block against sums computed from the driven pixels. The patterns used are zero difference, full-scale differences in both directions, ramps, random data, and blocks with idle gaps in the middle.

// File: rtl/sad_pkg.sv
// Package: sizing helpers shared by the SAD engine and its checker.
// Assumes block edges and row lengths are powers of two.
package sad_pkg;

    // Width needed to sum blk*blk unsigned values of pix_w bits.
    function automatic int sad_width(input int pix_w, input int blk);
        return pix_w + $clog2(blk * blk);
    endfunction

    // Width of the per-row partial sum over blk elements.
    function automatic int rowsum_width(input int pix_w, input int blk);
        return pix_w + $clog2(blk);
    endfunction

endpackage

// File: rtl/abs_diff_pe.sv
// Module: abs_diff_pe
// Purpose: one processing element, returns the unsigned magnitude of a - b.
// Assumes: both operands are unsigned pixels of the same width. Purely combinational.
module abs_diff_pe #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [PIX_W-1:0] d
);

    // Subtract the smaller operand from the larger.
    always_comb begin
        if (a >= b) d = a - b;
        else        d = b - a;
    end

endmodule

// File: rtl/row_sequencer.sv
// Module: row_sequencer
// Purpose: counts accepted rows of a block and derives the band index, the
// band-closing flag and the done strobe.
// Assumes: ROWS and BLK are powers of two and BLK divides ROWS.
module row_sequencer #(
    parameter int ROWS = 16,
    parameter int BLK  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic [$clog2(ROWS/BLK)-1:0] band_idx,
    output logic                      band_last,
    output logic                      done
);

    localparam int CNT_W  = $clog2(ROWS);
    localparam int LBLK   = $clog2(BLK);
    localparam int BAND_W = $clog2(ROWS/BLK);

    logic [CNT_W-1:0] row_cnt;
    logic             block_end;

    // Decode the current row position into band and in-band offset.
    always_comb begin
        band_idx  = row_cnt[CNT_W-1 -: BAND_W];
        band_last = (row_cnt[LBLK-1:0] == LBLK'(BLK-1));
        block_end = in_valid && (row_cnt == CNT_W'(ROWS-1));
    end

    // Advance the row count on accepted rows; wraps to zero after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) row_cnt <= '0;
        else if (in_valid) row_cnt <= row_cnt + 1'b1;
    end

    // Raise done for one cycle after the final row of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= block_end;
    end

endmodule

// File: rtl/sad_col_group.sv
// Module: sad_col_group
// Purpose: BLK adjacent processing elements, their adder, a running
// accumulator and the band demultiplexer for one column of sub-blocks.
// Assumes: band_last and band_sel come from the shared row sequencer and are
// only meaningful while in_valid is high.
module sad_col_group
    import sad_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int BLK   = 4,
    parameter int BANDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [BLK*PIX_W-1:0]           cand,
    input  logic [BLK*PIX_W-1:0]           cur,
    input  logic                           band_last,
    input  logic [$clog2(BANDS)-1:0]       band_sel,
    output logic [BANDS*sad_width(PIX_W, BLK)-1:0] band_sad
);

    localparam int SAD_W = sad_width(PIX_W, BLK);
    localparam int RS_W  = rowsum_width(PIX_W, BLK);

    logic [PIX_W-1:0] diff [BLK];
    logic [RS_W-1:0]  row_sum;
    logic [SAD_W-1:0] acc;
    logic [SAD_W-1:0] acc_next;
    logic [SAD_W-1:0] hold [BANDS];

    // One processing element per pixel column of the group.
    for (genvar i = 0; i < BLK; i++) begin : g_pe
        abs_diff_pe #(.PIX_W(PIX_W)) u_pe (
            .a (cand[i*PIX_W +: PIX_W]),
            .b (cur[i*PIX_W +: PIX_W]),
            .d (diff[i])
        );
    end

    // Add the group's magnitudes for this row, then add the running sum.
    always_comb begin
        row_sum = '0;
        for (int i = 0; i < BLK; i++) row_sum = row_sum + RS_W'(diff[i]);
        acc_next = acc + SAD_W'(row_sum);
    end

    // Accumulate rows; at a band's last row, store the sum and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            for (int b = 0; b < BANDS; b++) hold[b] <= '0;
        end else if (in_valid) begin
            if (band_last) begin
                acc            <= '0;
                hold[band_sel] <= acc_next;
            end else begin
                acc <= acc_next;
            end
        end
    end

    // Flatten the band registers for the top level.
    for (genvar b = 0; b < BANDS; b++) begin : g_out
        assign band_sad[b*SAD_W +: SAD_W] = hold[b];
    end

endmodule

// File: rtl/sad4x4_row_unit.sv
// Module: sad4x4_row_unit (top)
// Purpose: streams a candidate block and the current block row by row and
// produces all BLK x BLK sub-block SADs plus a done strobe.
// Assumes: rows of one block arrive in order top to bottom; the driver keeps
// count of rows itself and never aborts a block except through reset.
module sad4x4_row_unit
    import sad_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 16,
    parameter int BLK     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ROW_PIX*PIX_W-1:0]  cand_row,
    input  logic [ROW_PIX*PIX_W-1:0]  cur_row,
    output logic [(ROW_PIX/BLK)*(ROW_PIX/BLK)*sad_width(PIX_W, BLK)-1:0] sad_out,
    output logic                      done
);

    localparam int NGRP   = ROW_PIX / BLK;
    localparam int SAD_W  = sad_width(PIX_W, BLK);
    localparam int BAND_W = $clog2(NGRP);
    localparam int GRP_W  = BLK * PIX_W;

    logic [BAND_W-1:0]      band_idx;
    logic                   band_last;
    logic [NGRP*SAD_W-1:0]  grp_sad [NGRP];

    // Shared row counter, band decode and done strobe.
    row_sequencer #(.ROWS(ROW_PIX), .BLK(BLK)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .band_idx  (band_idx),
        .band_last (band_last),
        .done      (done)
    );

    // One column group per block column; outputs placed in raster order.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        sad_col_group #(.PIX_W(PIX_W), .BLK(BLK), .BANDS(NGRP)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .cand      (cand_row[g*GRP_W +: GRP_W]),
            .cur       (cur_row[g*GRP_W +: GRP_W]),
            .band_last (band_last),
            .band_sel  (band_idx),
            .band_sad  (grp_sad[g])
        );
        for (genvar b = 0; b < NGRP; b++) begin : g_map
            assign sad_out[(b*NGRP + g)*SAD_W +: SAD_W] = grp_sad[g][b*SAD_W +: SAD_W];
        end
    end

endmodule

// File: rtl/sad4x4_row_chk.sv
// Module: sad4x4_row_chk
// Purpose: port-level properties of sad4x4_row_unit, bound to every instance.
// Keeps its own count of accepted rows, independent of the design's counter.
module sad4x4_row_chk
    import sad_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 16,
    parameter int BLK     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [(ROW_PIX/BLK)*(ROW_PIX/BLK)*sad_width(PIX_W, BLK)-1:0] sad_out,
    input logic                      done
);

    localparam int NBLK  = (ROW_PIX/BLK) * (ROW_PIX/BLK);
    localparam int SAD_W = sad_width(PIX_W, BLK);
    localparam int MAXV  = BLK * BLK * ((1 << PIX_W) - 1);
    localparam int CW    = $clog2(ROW_PIX);

    logic [CW-1:0] ck_rows;

    // Independent count of accepted rows within the block.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_rows <= '0;
        else if (in_valid) ck_rows <= ck_rows + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sad_out == '0 && !done));

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ck_rows == CW'(ROW_PIX-1)) |=> done);

    // R6
    done_only_then_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && ck_rows == CW'(ROW_PIX-1)) |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sad_out));

    // R5
    for (genvar k = 0; k < NBLK; k++) begin : g_rng
        sad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sad_out[k*SAD_W +: SAD_W] <= SAD_W'(MAXV));
    end

endmodule

bind sad4x4_row_unit sad4x4_row_chk #(
    .PIX_W(PIX_W), .ROW_PIX(ROW_PIX), .BLK(BLK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sad_out(sad_out), .done(done)
);

// File: tb/sim_sad4x4_row_unit.sv
// Scoreboard bench: the driver pushes the expected SAD vector of each block,
// the monitor pops and compares it when done is seen.
module sim_sad4x4_row_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 8;
    localparam int ROWP  = 16;
    localparam int BLK   = 4;
    localparam int NBLK  = 16;
    localparam int SAD_W = 12;
    localparam int VW    = NBLK * SAD_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [ROWP*8-1:0]  cand_row = '0;
    logic [ROWP*8-1:0]  cur_row = '0;
    logic [VW-1:0]      sad_out;
    logic               done;

    int checks = 0;
    int fails  = 0;
    logic [VW-1:0] exp_q [$];
    logic prev_done = 1'b0;

    sad4x4_row_unit #(.PIX_W(PIX_W), .ROW_PIX(ROWP), .BLK(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cand_row(cand_row), .cur_row(cur_row),
        .sad_out(sad_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                         input logic [VW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Pixel generator: mode selects the pattern.
    function automatic logic [7:0] pix(input int mode, input int r, input int i, input bit is_cur);
        case (mode)
            0: return 8'((r*16 + i) * 7);                       // equal blocks
            1: return is_cur ? 8'd0 : 8'd255;                   // full scale, cand high
            2: return is_cur ? 8'd255 : 8'd0;                   // full scale, cur high
            3: return 8'($urandom);                             // random
            default: return is_cur ? 8'(255 - (i*16 + r)) : 8'(r*16 + i); // ramps
        endcase
    endfunction

    // Drive one block; gap_row >= 0 inserts idle cycles after that row.
    task automatic send_block(input int mode, input int gap_row);
        int sums [NBLK];
        logic [7:0] cv [ROWP][ROWP];
        logic [7:0] uv [ROWP][ROWP];
        logic [VW-1:0] expv;
        foreach (sums[k]) sums[k] = 0;
        for (int r = 0; r < ROWP; r++)
            for (int i = 0; i < ROWP; i++) begin
                cv[r][i] = pix(mode, r, i, 1'b0);
                uv[r][i] = pix(mode, r, i, 1'b1);
                // R2 magnitude, R3 grouping, R4 index
                sums[(r/4)*4 + i/4] += (cv[r][i] > uv[r][i]) ? int'(cv[r][i] - uv[r][i])
                                                             : int'(uv[r][i] - cv[r][i]);
            end
        for (int k = 0; k < NBLK; k++) expv[k*SAD_W +: SAD_W] = SAD_W'(sums[k]);
        exp_q.push_back(expv);
        for (int r = 0; r < ROWP; r++) begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int i = 0; i < ROWP; i++) begin
                cand_row[i*8 +: 8] = cv[r][i];
                cur_row[i*8 +: 8]  = uv[r][i];
            end
            if (r == gap_row) begin
                logic [VW-1:0] snap;
                @(negedge clk);
                in_valid = 1'b0;
                cand_row = {ROWP{8'hA5}};
                cur_row  = '0;
                snap = sad_out;
                repeat (3) @(negedge clk);
                // R7: idle cycles leave the outputs untouched
                check(sad_out == snap, "R7 hold", sad_out, snap);
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare results as done appears; done must be a single pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done)
                check(!done, "R6 single-cycle done", VW'(done), VW'(0));
            if (done) begin
                if (exp_q.size() == 0) check(1'b0, "R6 unexpected done", VW'(1), VW'(0));
                else begin
                    logic [VW-1:0] e;
                    e = exp_q.pop_front();
                    // R3 R4 R5 R8 block result
                    check(sad_out == e, "R3/R4 block SADs", sad_out, e);
                end
            end
            prev_done = done;
        end
    end

    initial begin
        // R1: reset with valid rows present
        rst_n = 1'b0;
        in_valid = 1'b1;
        cand_row = {ROWP{8'hFF}};
        cur_row = '0;
        repeat (3) @(negedge clk);
        check(sad_out == '0, "R1 reset sad_out", sad_out, '0);
        check(done == 1'b0, "R1 reset done", VW'(done), VW'(0));
        rst_n = 1'b1;
        in_valid = 1'b0;
        idle(2);

        send_block(0, -1); idle(2);            // R2 equal blocks give zero
        send_block(1, -1); idle(2);            // R5 full scale, 4080
        send_block(2, -1); idle(2);            // R2 R5 reverse direction
        send_block(4, 5);  idle(2);            // R7 gap inside a band
        send_block(3, 3);                       // R7 gap at band close
        send_block(3, -1);                      // R8 back to back
        send_block(1, -1);                      // R8 back to back
        send_block(4, -1); idle(1);
        send_block(3, 15); idle(4);             // R7 gap after last row
        idle(4);
        // R6 every block produced exactly one done
        check(exp_q.size() == 0, "R6 all blocks completed", VW'(exp_q.size()), VW'(0));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule